// File: doc/BRIEF.md
# Write-triggered mailbox interrupt controller

This block holds a bank of 64-bit mailboxes on a simple register port. A producer, either software or a device that sends message-signalled interrupts, writes a word into a mailbox. The block merges that word into the stored contents using the function programmed for that mailbox: replace, bitwise OR, or add. If the programmed trigger is the doorbell condition and the merged result has any bit that is also set in the mailbox's enable mask, the mailbox raises its own interrupt line for one clock. Each bit of a mailbox stands for one interrupt source.

The consumer reads the mailbox through one of two views. A plain read leaves the contents alone. A load-and-clear read returns the word and zeroes the mailbox in the same access, so pending bits are fetched and retired at once. Interrupts come only from writes. Changing the mask never raises a line, so software that enables a source re-posts its pending bit by writing it again in OR mode.

Every mailbox decodes a 0x200-byte window, and the mailbox index sits in the address bits above it. Inside the window the registers are placed as follows:

- contents at 0x0
- load-and-clear view at 0x8
- mask at 0x10
- function at 0x18

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every mailbox's contents, mask and function read as zero, all interrupt lines are low, and the read data output is zero.
- R2: With input mode 0 (function bits [7:0]), a write to the contents offset 0x0 replaces the stored word. Mode codes 3 to 255 behave the same way.
- R3: With input mode 1, a write ORs the written word into the stored word, and bits already set stay set.
- R4: With input mode 2, a write adds the written word to the stored word, modulo 2^64.
- R5: A read of offset 0x8 returns the stored word and leaves the mailbox at zero, so a following read of offset 0x0 returns zero.
- R6: A write to offset 0x8 is merged into the stored word through the programmed input mode, exactly as a write to offset 0x0 is.
- R7: With trigger code 1 (function bits [10:8]), a merging write whose result ANDed with the mask is nonzero raises that mailbox's interrupt line. The line is high in exactly the one cycle after the write, and it stays low when that AND is zero.
- R8: Trigger code 0 and trigger codes 2 to 7 never raise the interrupt line.
- R9: A write to the mask at offset 0x10 stores the full word, reads back unchanged, and never raises an interrupt line by itself.
- R10: The function register at 0x18 keeps written bits [10:0] and reads zero in bits [63:11].
- R11: Reads of any other offset in the window return zero. Writes to such offsets change no register and raise no interrupt.
- R12: When a read and a write target the same address in the same cycle, the write is applied first. The read returns the value after the write. On offset 0x8 the mailbox is then left at zero, and the interrupt decision uses the merged value.
- R13: Read data appears on the output in the cycle after the read strobe and holds until the next read.
- R14: A write to one mailbox changes neither the contents nor the interrupt line of any other mailbox.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (log2(NUM_MBOX)+9) | Byte address: mailbox index above bit 9, register offset in bits [8:0] |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | NUM_MBOX | One interrupt line per mailbox, pulsed for one cycle |

## Verification
A merging write and a read can land on the same mailbox in the same cycle. The hard case is a load-and-clear read together with an OR-mode doorbell write. The bench provokes this by raising both strobes on one address in a single cycle, on the contents, load-and-clear and mask offsets. It judges the outcome on four observations:

- the read data carries the post-write word;
- a later read shows the mailbox cleared after the load-and-clear case;
- the interrupt line pulses because the merged word met the mask;
- a later mask read shows the mask left as written.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Byte window decoded by one mailbox
  localparam int WIN_BITS = 9;

  // Register offsets inside a window
  localparam logic [WIN_BITS-1:0] OFS_VALUE = 9'h000;
  localparam logic [WIN_BITS-1:0] OFS_LAC   = 9'h008;
  localparam logic [WIN_BITS-1:0] OFS_MASK  = 9'h010;
  localparam logic [WIN_BITS-1:0] OFS_FUNC  = 9'h018;

  // Input-mode codes, function bits [7:0]
  localparam logic [7:0] MODE_OVERWRITE = 8'd0;
  localparam logic [7:0] MODE_OR        = 8'd1;
  localparam logic [7:0] MODE_ADD       = 8'd2;

  // Trigger codes, function bits [10:8]
  localparam logic [2:0] TRG_NONE     = 3'd0;
  localparam logic [2:0] TRG_DOORBELL = 3'd1;

  localparam int FUNC_W = 11;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_VALUE,
    SEL_LAC,
    SEL_MASK,
    SEL_FUNC
  } reg_sel_e;

  typedef struct packed {
    logic [2:0] trig;
    logic [7:0] mode;
  } func_t;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int NUM_MBOX = 8,
  parameter int IDX_W    = 3,
  parameter int ADDR_W   = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_MBOX);

  logic [WIN_BITS-1:0] ofs;
  logic                in_range;

  assign idx      = addr[ADDR_W-1:WIN_BITS];
  assign ofs      = addr[WIN_BITS-1:0];
  assign in_range = ({1'b0, idx} < LIMIT);

  always_comb begin
    sel = SEL_NONE;
    if (in_range) begin
      case (ofs)
        OFS_VALUE: sel = SEL_VALUE;
        OFS_LAC:   sel = SEL_LAC;
        OFS_MASK:  sel = SEL_MASK;
        OFS_FUNC:  sel = SEL_FUNC;
        default:   sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/mbox_combine.sv
module mbox_combine
  import mbox_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [7:0]        mode,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] in_word,
  output logic [DATA_W-1:0] new_word
);

  always_comb begin
    case (mode)
      MODE_OR:  new_word = old_word | in_word;
      MODE_ADD: new_word = old_word + in_word;
      default:  new_word = in_word;  // overwrite and unknown codes
    endcase
  end

endmodule

// File: rtl/mbox_cell.sv
module mbox_cell
  import mbox_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_word,   // write to contents or load-and-clear offset
  input  logic              wr_mask,
  input  logic              wr_func,
  input  logic              rd_clear,  // load-and-clear read
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] view_word, // post-write views for the read path
  output logic [DATA_W-1:0] view_mask,
  output logic [DATA_W-1:0] view_func,
  output logic              irq
);

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] mask_q;
  func_t             func_q;
  logic [DATA_W-1:0] merged;
  logic              fire;

  mbox_combine #(.DATA_W(DATA_W)) u_comb (
    .mode     (func_q.mode),
    .old_word (word_q),
    .in_word  (wdata),
    .new_word (merged)
  );

  assign fire = wr_word && (func_q.trig == TRG_DOORBELL) && ((merged & mask_q) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      mask_q <= '0;
      func_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (rd_clear)
        word_q <= '0;
      else if (wr_word)
        word_q <= merged;
      if (wr_mask)
        mask_q <= wdata;
      if (wr_func)
        func_q <= func_t'(wdata[FUNC_W-1:0]);
      irq <= fire;
    end
  end

  assign view_word = wr_word ? merged : word_q;
  assign view_mask = wr_mask ? wdata : mask_q;
  assign view_func = wr_func ? {{(DATA_W-FUNC_W){1'b0}}, wdata[FUNC_W-1:0]}
                             : {{(DATA_W-FUNC_W){1'b0}}, func_q};

endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_pkg::*;
#(
  parameter  int NUM_MBOX = 8,
  parameter  int DATA_W   = 64,
  localparam int IDX_W    = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1,
  localparam int ADDR_W   = IDX_W + WIN_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_re,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_MBOX-1:0] irq_out
);

  generate
    if (NUM_MBOX < 1 || NUM_MBOX > 128) begin : g_bad_count
      $error("NUM_MBOX must lie in 1..128");
    end
    if (DATA_W < FUNC_W) begin : g_bad_width
      $error("DATA_W too narrow for the function fields");
    end
  endgenerate

  reg_sel_e          dec_sel;
  logic [IDX_W-1:0]  dec_idx;
  logic [DATA_W-1:0] view_word [NUM_MBOX];
  logic [DATA_W-1:0] view_mask [NUM_MBOX];
  logic [DATA_W-1:0] view_func [NUM_MBOX];
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;

  mbox_decode #(
    .NUM_MBOX (NUM_MBOX),
    .IDX_W    (IDX_W),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .addr (bus_addr),
    .sel  (dec_sel),
    .idx  (dec_idx)
  );

  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_cell
    logic hit;
    assign hit = (dec_idx == IDX_W'(i));

    mbox_cell #(.DATA_W(DATA_W)) u_cell (
      .clk       (clk),
      .rst       (rst),
      .wr_word   (bus_we && hit && (dec_sel == SEL_VALUE || dec_sel == SEL_LAC)),
      .wr_mask   (bus_we && hit && (dec_sel == SEL_MASK)),
      .wr_func   (bus_we && hit && (dec_sel == SEL_FUNC)),
      .rd_clear  (bus_re && hit && (dec_sel == SEL_LAC)),
      .wdata     (bus_wdata),
      .view_word (view_word[i]),
      .view_mask (view_mask[i]),
      .view_func (view_func[i]),
      .irq       (irq_out[i])
    );
  end

  // Read path sees the word after any write in the same cycle
  always_comb begin
    case (dec_sel)
      SEL_VALUE, SEL_LAC: rd_word = view_word[dec_idx];
      SEL_MASK:           rd_word = view_mask[dec_idx];
      SEL_FUNC:           rd_word = view_func[dec_idx];
      default:            rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (bus_re)
      rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int NUM_MBOX = 8,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic                bus_re,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_MBOX-1:0] irq_out
);

  localparam int IDX_W = ADDR_W - 9;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_MBOX);

  logic [8:0] ofs;
  logic       mapped;

  assign ofs    = bus_addr[8:0];
  assign mapped = ({1'b0, bus_addr[ADDR_W-1:9]} < LIMIT) &&
                  (ofs == 9'h000 || ofs == 9'h008 || ofs == 9'h010 || ofs == 9'h018);

  // R1: first cycle out of reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_out == '0 && bus_rdata == '0));

  // R9: no write in the previous cycle, so no interrupt now
  a_r9_irq_needs_write: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> $past(bus_we));

  // R14: one write per cycle reaches at most one mailbox
  a_r14_one_irq: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_out));

  // R11: writes outside the map stay silent
  a_r11_unmapped_silent: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !mapped) |=> (irq_out == '0));

  // R13: read data holds without a read strobe
  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

endmodule

bind mbox_irq_ctrl mbox_irq_chk #(
  .NUM_MBOX (NUM_MBOX),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out)
);

// File: tb/test_mbox_irq_ctrl.sv
module test_mbox_irq_ctrl;

  localparam int NMB = 8;
  localparam int AW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [63:0]   bus_wdata = '0;
  logic          bus_re = 1'b0;
  logic [63:0]   bus_rdata;
  logic [NMB-1:0] irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mbox_irq_ctrl #(.NUM_MBOX(NMB), .DATA_W(64)) i_mbox_irq_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  function automatic logic [AW-1:0] ad(int m, logic [8:0] o);
    return {3'(m), o};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data one cycle after each read strobe
  always @(posedge clk) rd_pend <= bus_re;

  always @(negedge clk) begin
    if (rd_pend && !rst) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard underflow", bus_rdata, 64'hx);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [63:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [63:0] e, string tag);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic rw(logic [AW-1:0] a, logic [63:0] d, logic [63:0] e, string tag);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
  endtask

  task automatic irq_is(logic [63:0] e, string tag);
    chk(tag, 64'(irq_out), e);
  endtask

  // Write, check the line in the next cycle, then check that it drops
  task automatic wr_irq(logic [AW-1:0] a, logic [63:0] d, logic [63:0] e, string tag);
    wr(a, d);
    irq_is(e, tag);
    @(negedge clk);
    irq_is(64'h0, {tag, " pulse end"});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    irq_is(64'h0, "R1 irq after reset");
    chk("R1 rdata after reset", bus_rdata, 64'h0);
    rd(ad(0, 9'h000), 64'h0, "R1 value");
    rd(ad(0, 9'h010), 64'h0, "R1 mask");
    rd(ad(0, 9'h018), 64'h0, "R1 func");
    rd(ad(5, 9'h008), 64'h0, "R1 lac");

    // R10 function field readback
    wr(ad(0, 9'h018), 64'hFFFF_0000_0000_F902);
    rd(ad(0, 9'h018), 64'h102, "R10 func bits");
    wr(ad(0, 9'h018), 64'h100);  // overwrite, doorbell

    // R7 zero mask blocks the line
    wr_irq(ad(0, 9'h000), 64'h5, 64'h0, "R7 masked doorbell");
    rd(ad(0, 9'h000), 64'h5, "R2 overwrite value");
    // R9 mask write alone never fires
    wr_irq(ad(0, 9'h010), 64'h4, 64'h0, "R9 mask write no irq");
    rd(ad(0, 9'h010), 64'h4, "R9 mask readback");
    wr_irq(ad(0, 9'h000), 64'h3, 64'h0, "R7 result misses mask");
    wr_irq(ad(0, 9'h000), 64'hC, 64'h1, "R7 doorbell fires");
    rd(ad(0, 9'h000), 64'hC, "R2 overwrite replaces");

    // R2 unknown mode acts as overwrite
    wr(ad(0, 9'h018), 64'h107);
    wr(ad(0, 9'h000), 64'h1);
    rd(ad(0, 9'h000), 64'h1, "R2 unknown mode overwrite");

    // R3 OR mode
    wr(ad(0, 9'h018), 64'h101);
    wr_irq(ad(0, 9'h000), 64'h10, 64'h0, "R3 or no mask hit");
    wr_irq(ad(0, 9'h000), 64'h4, 64'h1, "R3 or fires");
    rd(ad(0, 9'h000), 64'h15, "R3 or keeps bits");

    // R5 load-and-clear read
    rd(ad(0, 9'h008), 64'h15, "R5 lac returns");
    rd(ad(0, 9'h000), 64'h0, "R5 lac cleared");

    // R6 write through load-and-clear offset merges
    wr(ad(0, 9'h000), 64'h1);
    wr(ad(0, 9'h008), 64'h2);
    rd(ad(0, 9'h000), 64'h3, "R6 lac write merges");

    // R4 add mode with wrap
    wr(ad(0, 9'h018), 64'h102);
    wr_irq(ad(0, 9'h000), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R4 add wrap no irq");
    rd(ad(0, 9'h000), 64'h2, "R4 add wrap");
    wr_irq(ad(0, 9'h000), 64'h2, 64'h1, "R4 add fires");
    rd(ad(0, 9'h000), 64'h4, "R4 add sum");

    // R8 non-doorbell triggers stay silent
    wr(ad(0, 9'h010), 64'hFFFF_FFFF_FFFF_FFFF);
    wr(ad(0, 9'h018), 64'h001);
    wr_irq(ad(0, 9'h000), 64'hFF, 64'h0, "R8 trigger 0");
    wr(ad(0, 9'h018), 64'h201);
    wr_irq(ad(0, 9'h000), 64'h1, 64'h0, "R8 trigger 2");
    wr(ad(0, 9'h018), 64'h401);
    wr_irq(ad(0, 9'h000), 64'h1, 64'h0, "R8 trigger 4");
    wr(ad(0, 9'h018), 64'h701);
    wr_irq(ad(0, 9'h000), 64'h1, 64'h0, "R8 trigger 7");

    // R11 unmapped offsets
    wr(ad(0, 9'h018), 64'h101);
    wr_irq(ad(0, 9'h020), 64'hDEAD, 64'h0, "R11 unmapped write silent");
    wr_irq(ad(0, 9'h004), 64'hBEEF, 64'h0, "R11 misaligned write silent");
    rd(ad(0, 9'h000), 64'hFF, "R11 value untouched");
    rd(ad(0, 9'h010), 64'hFFFF_FFFF_FFFF_FFFF, "R11 mask untouched");
    rd(ad(0, 9'h018), 64'h101, "R11 func untouched");
    rd(ad(0, 9'h020), 64'h0, "R11 unmapped read");
    rd(ad(0, 9'h1F8), 64'h0, "R11 high offset read");

    // R14 independence
    wr(ad(3, 9'h018), 64'h101);
    wr(ad(3, 9'h010), 64'h1);
    wr_irq(ad(3, 9'h000), 64'h1, 64'h8, "R14 only mailbox 3 fires");
    rd(ad(0, 9'h000), 64'hFF, "R14 mailbox 0 untouched");
    rd(ad(3, 9'h000), 64'h1, "R14 mailbox 3 value");

    // R12 same-cycle read and write
    rw(ad(3, 9'h000), 64'h2, 64'h3, "R12 read sees write");
    irq_is(64'h8, "R12 irq from value rw");
    rw(ad(3, 9'h008), 64'h4, 64'h7, "R12 lac sees merged");
    irq_is(64'h8, "R12 irq from merged lac");
    rd(ad(3, 9'h000), 64'h0, "R12 lac leaves zero");
    rw(ad(3, 9'h010), 64'h6, 64'h6, "R12 mask rw");

    // R13 read data holds
    repeat (2) @(negedge clk);
    chk("R13 rdata holds", bus_rdata, 64'h6);
    rd(ad(3, 9'h010), 64'h6, "R13 mask kept");

    repeat (3) @(negedge clk);
    chk("R13 scoreboard drained", 64'(exp_q.size()), 64'h0);
    finish_run();
  end

endmodule